// File: doc/BRIEF.md
# Dual-Strobe Burst SRAM Cycle Controller

This block sits in front of a small word-addressed array. It behaves like the control logic of a flow-through synchronous burst SRAM with a shared data path. On every rising clock edge it looks at three chip selects, two active-low address strobes, an advance input and the write controls. From these it classifies the cycle as idle, deselect, new read, new write, burst continue or burst suspend. It loads or steps a two-bit burst counter and issues per-lane write strobes to the array.

Read data comes straight out of the array at the registered burst address, in the same cycle as the edge that chose it. The bidirectional bus is split into separate input data, output data and an output-drive flag, which is meant to control an external tristate buffer. One strobe comes from the processor side and the other from the cache-controller side. The processor strobe always wins and always opens with a read.

Top module: `ssram_cycle_ctrl`

## Requirements
- R1: A strobe cycle starts an access only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 at the edge. If either strobe is recognised while this condition fails, the cycle is a deselect: the burst ends and `rdata_oe` is 0 in the cycle that follows.
- R2: When `pstb_n` and `cstb_n` are both low with the chip selected, only the processor strobe is taken, so the cycle is a read even if the write controls are active.
- R3: `pstb_n` low is ignored while `sel1_n` is high. With `cstb_n` high, that edge is handled as a cycle with no strobe, so a running burst continues or suspends.
- R4: A cycle opened by `pstb_n` is a read on its first edge, whatever `gwr_n`, `bwr_n` and `lane_sel_n` are. The array is left unchanged.
- R5: A cycle opened by `cstb_n`, with the processor strobe not recognised, writes `wdata` to `addr` at that same edge if the write controls request a write. Otherwise it is a read.
- R6: A write is requested when `gwr_n`=0, or when `bwr_n`=0 and at least one bit of `lane_sel_n` is 0. `gwr_n`=0 writes all four lanes. Otherwise lane i is written only when `bwr_n`=0 and `lane_sel_n[i]`=0. Lane i is bits [9i+8:9i] (8 data bits and 1 parity bit).
- R7: The two low address bits come from a counter loaded from `addr[1:0]`, and the upper bits stay fixed for the whole burst. With `burst_ilv`=0 (sampled when the strobe is taken), beat k uses start+k mod 4. With `burst_ilv`=1, beat k uses start XOR k.
- R8: On an edge with no strobe recognised during an open burst, `adv_n`=0 moves to the next burst address and `adv_n`=1 stays on the current one. The write controls then decide whether that beat is a read or a write. With no burst open, such an edge does nothing.
- R9: `rdata_oe` is 0 after any write edge, even when `oe_n` is 0. It is also 0 while `oe_n` is 1 and while the chip is deselected or idle.
- R10: In the first cycle of a read that starts from the idle or deselected state, `rdata_oe` stays 0 regardless of `oe_n`. A read started while a burst is already open drives in its first cycle.
- R11: Reset (`rst_n`=0, asynchronous) clears the array to zero, closes any burst and forces `rdata_oe` to 0.
- R12: While `rdata_oe` is 1, `rdata` equals the array word at the address chosen at the last edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| pstb_n | input | 1 | Processor address strobe, active low, highest priority |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Write-all-lanes control, active low |
| bwr_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address taken on a strobe |
| oe_n | input | 1 | Output enable, active low, combinational |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rdata_oe | output | 1 | Drive enable for the external data buffer |

## Verification
A wrong cycle classification appears as a lane write that should not happen, or one that goes missing. That is seen as a wrong `rdata` word the next time that address is read back. A wrong drive decision changes `rdata_oe` in the very next cycle. A burst counter that has drifted shows as the neighbouring word on `rdata` one cycle after the faulty advance or suspend edge. The wrap and interleave orders are checked over four beats in each mode, so an error there appears within one burst.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_DESEL,
        CYC_NEW_RD,
        CYC_NEW_WR,
        CYC_CONT_RD,
        CYC_CONT_WR,
        CYC_SUSP_RD,
        CYC_SUSP_WR
    } cyc_e;

    function automatic logic cyc_is_write(cyc_e k);
        return (k == CYC_NEW_WR) || (k == CYC_CONT_WR) || (k == CYC_SUSP_WR);
    endfunction

    function automatic logic cyc_is_read(cyc_e k);
        return (k == CYC_NEW_RD) || (k == CYC_CONT_RD) || (k == CYC_SUSP_RD);
    endfunction

endpackage

// File: rtl/ssram_burst_addr.sv
module ssram_burst_addr #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_lo,
    input  logic [CNT_W-1:0] beat,
    input  logic             ilv,
    output logic [CNT_W-1:0] lo
);
    always_comb begin
        if (ilv) lo = start_lo ^ beat;
        else     lo = start_lo + beat;
    end
endmodule

// File: rtl/ssram_cycle_dec.sv
module ssram_cycle_dec
    import ssram_pkg::*;
(
    input  logic sel1_n,
    input  logic sel2,
    input  logic sel3_n,
    input  logic pstb_n,
    input  logic cstb_n,
    input  logic adv_n,
    input  logic wr_req,
    input  logic burst_open,
    output cyc_e kind,
    output logic load,
    output logic advance
);
    logic chip_on;
    logic p_hit;
    logic c_hit;

    always_comb begin
        chip_on = !sel1_n && sel2 && !sel3_n;
        p_hit   = !pstb_n && !sel1_n;
        c_hit   = !cstb_n && !p_hit;
        kind    = CYC_IDLE;
        load    = 1'b0;
        advance = 1'b0;
        if (p_hit || c_hit) begin
            if (chip_on) begin
                load = 1'b1;
                kind = (p_hit || !wr_req) ? CYC_NEW_RD : CYC_NEW_WR;
            end else begin
                kind = CYC_DESEL;
            end
        end else if (burst_open) begin
            advance = !adv_n;
            if (!adv_n) kind = wr_req ? CYC_CONT_WR : CYC_CONT_RD;
            else        kind = wr_req ? CYC_SUSP_WR : CYC_SUSP_RD;
        end
    end
endmodule

// File: rtl/ssram_byte_array.sv
module ssram_byte_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
            end else if (lane_we[g]) begin
                mem_q[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem_q[raddr];
    end
endmodule

// File: rtl/ssram_cycle_ctrl.sv
module ssram_cycle_ctrl
    import ssram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int CNT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    pstb_n,
    input  logic                    cstb_n,
    input  logic                    adv_n,
    input  logic                    gwr_n,
    input  logic                    bwr_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    burst_ilv,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int HI_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic             active;
        logic             ilv;
        logic [HI_W-1:0]  hi;
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] cnt;
        logic             rd;
        logic             first;
    } st_t;

    st_t st_d, st_q;

    logic              wr_req;
    cyc_e              kind;
    logic              load;
    logic              advance;
    logic [CNT_W-1:0]  cnt_use;
    logic [CNT_W-1:0]  lo_cur;
    logic [CNT_W-1:0]  lo_nxt;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] cyc_addr;
    logic [LANES-1:0]  lane_we;

    assign wr_req  = !gwr_n || (!bwr_n && (lane_sel_n != '1));
    assign cnt_use = advance ? st_q.cnt + CNT_W'(1) : st_q.cnt;

    ssram_cycle_dec u_dec (
        .sel1_n     (sel1_n),
        .sel2       (sel2),
        .sel3_n     (sel3_n),
        .pstb_n     (pstb_n),
        .cstb_n     (cstb_n),
        .adv_n      (adv_n),
        .wr_req     (wr_req),
        .burst_open (st_q.active),
        .kind       (kind),
        .load       (load),
        .advance    (advance)
    );

    ssram_burst_addr #(.CNT_W(CNT_W)) u_cur (
        .start_lo (st_q.start),
        .beat     (st_q.cnt),
        .ilv      (st_q.ilv),
        .lo       (lo_cur)
    );

    ssram_burst_addr #(.CNT_W(CNT_W)) u_nxt (
        .start_lo (st_q.start),
        .beat     (cnt_use),
        .ilv      (st_q.ilv),
        .lo       (lo_nxt)
    );

    assign rd_addr  = {st_q.hi, lo_cur};
    assign cyc_addr = load ? addr : {st_q.hi, lo_nxt};

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_we[i] = cyc_is_write(kind) && (!gwr_n || (!bwr_n && !lane_sel_n[i]));
        end
    end

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.active = 1'b1;
            st_d.ilv    = burst_ilv;
            st_d.hi     = addr[ADDR_W-1:CNT_W];
            st_d.start  = addr[CNT_W-1:0];
            st_d.cnt    = '0;
            st_d.rd     = (kind == CYC_NEW_RD);
            st_d.first  = (kind == CYC_NEW_RD) && !st_q.active;
        end else if (kind == CYC_DESEL) begin
            st_d.active = 1'b0;
            st_d.rd     = 1'b0;
            st_d.first  = 1'b0;
        end else if (st_q.active) begin
            st_d.cnt    = cnt_use;
            st_d.rd     = cyc_is_read(kind);
            st_d.first  = 1'b0;
        end else begin
            st_d.rd     = 1'b0;
            st_d.first  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ssram_byte_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .waddr   (cyc_addr),
        .wdata   (wdata),
        .raddr   (rd_addr),
        .rdata   (rdata)
    );

    assign rdata_oe = st_q.rd && !st_q.first && !oe_n;

    p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_DESEL) |=> !rdata_oe);

    p_proc_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && !cstb_n && !sel1_n && sel2 && !sel3_n) |-> (kind == CYC_NEW_RD));

    p_proc_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && !sel1_n) |-> (lane_we == '0));

    p_suspend_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_SUSP_RD || kind == CYC_SUSP_WR) |=> $stable(rd_addr));

    p_write_hides_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |=> !rdata_oe);

    p_first_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_NEW_RD && !st_q.active) |=> !rdata_oe);

endmodule

// File: tb/tb_ssram_cycle_ctrl.sv
module tb_ssram_cycle_ctrl;
    localparam int AW = 6;
    localparam int DW = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel1_n, sel2, sel3_n, pstb_n, cstb_n, adv_n, gwr_n, bwr_n, burst_ilv, oe_n;
    logic [3:0]    lane_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic          rdata_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ssram_cycle_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .gwr_n(gwr_n), .bwr_n(bwr_n),
        .lane_sel_n(lane_sel_n), .burst_ilv(burst_ilv), .addr(addr), .oe_n(oe_n),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    typedef struct packed {
        logic s1n, s2, s3n, pn, cn, advn, gwn, bwn;
        logic [3:0]    lsn;
        logic          ilv;
        logic [AW-1:0] a;
        logic          oen;
        logic [DW-1:0] wd;
        logic          eoe;
        logic [DW-1:0] ed;
    } vec_t;

    localparam logic [DW-1:0] DA = 36'h0_AAAA_0001;
    localparam logic [DW-1:0] DB = 36'h1_BBBB_0002;
    localparam logic [DW-1:0] DC = 36'h2_CCCC_0003;
    localparam logic [DW-1:0] DD = 36'h3_DDDD_0004;
    localparam logic [DW-1:0] DE = 36'hF_EEEE_EEEE;
    localparam logic [DW-1:0] DF = 36'hA_BCDE_F012;
    localparam logic [DW-1:0] DF_M = 36'h0_04DC_0012; // lanes 0 and 2 of DF
    localparam logic [DW-1:0] DG = 36'h5_5555_5555;
    localparam logic [3:0] NL = 4'hF;
    localparam int NV = 30;

    localparam vec_t VEC [NV] = '{
        '{0,1,0,1,0,1,0,1,NL,0,6'd8 ,0,DA,0,'0},  // 0  R9 write start, bus off
        '{0,1,0,1,1,0,0,1,NL,0,6'd0 ,0,DB,0,'0},  // 1  R8 continue write addr 9
        '{0,1,0,1,1,0,0,1,NL,0,6'd0 ,0,DC,0,'0},  // 2  R8 addr 10
        '{0,1,0,1,1,0,0,1,NL,0,6'd0 ,0,DD,0,'0},  // 3  R8 addr 11
        '{0,1,0,1,0,1,1,1,NL,0,6'd8 ,0,'0,1,DA},  // 4  R5 readback, R10 open burst drives
        '{0,1,0,1,1,0,1,1,NL,0,6'd0 ,0,'0,1,DB},  // 5  R8
        '{0,1,0,1,1,1,1,1,NL,0,6'd0 ,0,'0,1,DB},  // 6  R8 suspend
        '{0,1,0,1,1,0,1,1,NL,0,6'd0 ,1,'0,0,'0},  // 7  R9 oe_n high
        '{0,1,0,1,1,0,1,1,NL,0,6'd0 ,0,'0,1,DD},  // 8  R7
        '{0,1,0,1,1,0,1,1,NL,0,6'd0 ,0,'0,1,DA},  // 9  R7 linear wrap
        '{0,0,0,1,0,1,1,1,NL,0,6'd8 ,0,'0,0,'0},  // 10 R1 sel2 low
        '{0,1,0,0,1,1,1,1,NL,0,6'd10,0,'0,0,'0},  // 11 R10 first read masked
        '{0,1,0,1,1,0,1,1,NL,0,6'd0 ,0,'0,1,DD},  // 12 R12
        '{0,1,0,0,0,1,0,1,NL,0,6'd9 ,0,DE,1,DB},  // 13 R2 both strobes
        '{0,1,0,1,1,1,1,1,NL,0,6'd0 ,0,'0,1,DB},  // 14 R4 no write happened
        '{0,1,0,1,0,1,1,1,NL,1,6'd9 ,0,'0,1,DB},  // 15 R7 interleaved start 01
        '{0,1,0,1,1,0,1,1,NL,0,6'd0 ,0,'0,1,DA},  // 16 R7 01^01
        '{0,1,0,1,1,0,1,1,NL,0,6'd0 ,0,'0,1,DD},  // 17 R7 01^10
        '{0,1,0,1,1,0,1,1,NL,0,6'd0 ,0,'0,1,DC},  // 18 R7 01^11
        '{1,1,0,0,1,1,1,1,NL,0,6'd0 ,0,'0,1,DC},  // 19 R3 gated pstb, suspend
        '{0,1,0,1,0,1,1,0,4'b1010,0,6'd12,0,DF,0,'0}, // 20 R6 lanes 0,2
        '{0,1,0,1,1,1,1,0,NL,0,6'd0 ,0,'0,1,DF_M},    // 21 R6 no lane selected: read
        '{0,1,0,1,1,1,0,1,NL,0,6'd0 ,0,DG,0,'0},      // 22 R6 global write
        '{0,1,0,1,1,1,1,1,NL,0,6'd0 ,0,'0,1,DG},      // 23 R6
        '{0,1,0,1,1,1,1,1,4'h0,0,6'd0,0,DE,1,DG},     // 24 R6 selects without lane enable
        '{0,1,1,1,0,1,1,1,NL,0,6'd12,0,'0,0,'0},      // 25 R1 sel3 high
        '{0,1,0,1,1,0,1,1,NL,0,6'd0 ,0,'0,0,'0},      // 26 R8 no burst open
        '{1,1,0,1,0,1,1,1,NL,0,6'd12,0,'0,0,'0},      // 27 R1 sel1 high
        '{0,1,0,1,0,1,1,1,NL,0,6'd12,0,'0,0,'0},      // 28 R10 first masked
        '{0,1,0,1,1,1,1,1,NL,0,6'd0 ,0,'0,1,DG}       // 29 R12
    };

    function automatic string req_of(int i);
        case (i)
            0, 7:              return "R9";
            1, 2, 3, 5, 6, 26: return "R8";
            4:                 return "R5";
            8, 9, 15, 16, 17, 18: return "R7";
            10, 25, 27:        return "R1";
            11, 28:            return "R10";
            13:                return "R2";
            14:                return "R4";
            19:                return "R3";
            20, 21, 22, 23, 24: return "R6";
            default:           return "R12";
        endcase
    endfunction

    task automatic apply(input vec_t v);
        sel1_n = v.s1n; sel2 = v.s2; sel3_n = v.s3n;
        pstb_n = v.pn;  cstb_n = v.cn; adv_n = v.advn;
        gwr_n = v.gwn;  bwr_n = v.bwn; lane_sel_n = v.lsn;
        burst_ilv = v.ilv; addr = v.a; oe_n = v.oen; wdata = v.wd;
    endtask

    task automatic check(input string req, input logic eoe, input logic [DW-1:0] ed);
        n_run++;
        if (rdata_oe !== eoe || (eoe && rdata !== ed)) begin
            n_fail++;
            $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", req, rdata_oe, rdata, eoe, ed);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    localparam vec_t IDLE_V = '{1,1,0,1,1,1,1,1,NL,0,6'd0,0,'0,0,'0};

    initial begin
        apply(IDLE_V);
        oe_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", 1'b0, '0); // reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(posedge clk);
            @(negedge clk);
            check(req_of(i), VEC[i].eoe, VEC[i].ed);
        end
        // R11: reset in the middle of an open read burst
        apply('{0,1,0,1,1,1,1,1,NL,0,6'd0,0,'0,1,DG});
        @(posedge clk); @(negedge clk);
        check("R11", 1'b1, DG);
        rst_n = 1'b0;
        #2;
        check("R11", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        apply('{0,1,0,1,1,0,1,1,NL,0,6'd0,0,'0,0,'0});
        @(posedge clk); @(negedge clk);
        check("R11", 1'b0, '0); // no burst survives reset
        apply('{0,1,0,1,0,1,1,1,NL,0,6'd12,0,'0,0,'0});
        @(posedge clk); @(negedge clk);
        check("R11", 1'b0, '0); // first read after reset is masked
        apply('{0,1,0,1,1,1,1,1,NL,0,6'd0,0,'0,1,'0});
        @(posedge clk); @(negedge clk);
        check("R11", 1'b1, '0); // array cleared by reset
        done = 1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end
endmodule